// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the host-visible control and status register set of a DMA controller with up to 64 channels. For every channel it keeps four one-bit states: a request enable, an error-interrupt enable, a pending interrupt and a pending error. Each of these 64-bit bitmaps is seen by software as two 32-bit words, the high word for channels 63..32 and the low word for channels 31..0. It also holds a small configuration word, drives a one-cycle start pulse toward the transfer engine of a chosen channel, and merges everything pending into one interrupt line.

Software changes single channel bits without a read-modify-write by writing a channel number into one of several byte-wide command slots. Transfer engines report through plain strobes. A completion strobe marks a pending interrupt. An error strobe marks a pending error and carries the channel number and a set of cause flags. The first error is frozen in an error status word until software releases it, so later faults cannot hide the one that came first. A strobe always beats a clear that arrives in the same cycle, so no event is lost.

Top module: `dma_creg`

## Requirements
- R1: After reset, every readable register reads 0, and `irq`, `req_enable`, `start_pulse` and the configuration outputs are 0.
- R2: The configuration word at 0x00 stores only bit 31 (clock gating enable), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). Its other bits read 0. The three bits drive `cfg_clk_gate`, `cfg_rr_group` and `cfg_rr_chan`.
- R3: The request-enable words (0x08 high, 0x0C low) and the error-interrupt-enable words (0x10 high, 0x14 low) are read/write, byte by byte under `bus_be`. The high word holds channels 63..32 and the low word holds channels 31..0. `req_enable` mirrors the request-enable bitmap.
- R4: Byte command slots take a channel number in the byte. Byte offset 0x18+k is byte lane k of the word at 0x18, and 0x1C+k is lane k of the word at 0x1C. The slots are: 0x18 set request enable, 0x19 clear request enable, 0x1A set error-interrupt enable, 0x1B clear error-interrupt enable, 0x1C clear pending interrupt, 0x1D clear pending error. Values of NUM_CH or more, and any write to 0x1F, change nothing.
- R5: Writing channel c to slot 0x1E raises `start_pulse[c]` alone, for exactly the one cycle after the write edge.
- R6: `done_evt[c]` sets channel c's pending-interrupt bit (words 0x20 high, 0x24 low). A cycle with `err_evt` set sets the pending-error bit of channel `err_chan` (words 0x28 high, 0x2C low).
- R7: The pending-interrupt and pending-error words are write-one-to-clear. A 1 clears its bit and a 0 leaves it unchanged.
- R8: When a set strobe and a clear (by word or by command) hit the same bit in the same cycle, the bit ends up set.
- R9: On capture, the error status word at 0x04 holds: bit 31 valid; bits 13..8 `err_chan`; `err_flags[9]` in bit 15 and `err_flags[8]` in bit 14; `err_flags[7:0]` in bits 7..0. All other bits are 0.
- R10: While the valid bit is set, new errors still set their pending-error bits but leave the error status word unchanged.
- R11: A write to 0x04 with byte lane 3 enabled and bit 31 set clears the error status word. Other writes to it have no effect. An error arriving in the same cycle as the clear is captured.
- R12: `irq` is high exactly when any pending-interrupt bit is set, or any pending-error bit whose error-interrupt enable is set.
- R13: Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the accessed 32-bit word |
| bus_be | input | 4 | Byte lane enables, lane k = bits 8k+7..8k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| done_evt | input | NUM_CH | Per-channel completion strobes |
| err_evt | input | 1 | Error strobe from a transfer engine |
| err_chan | input | 6 | Channel number of the error |
| err_flags | input | 10 | Error cause flags |
| req_enable | output | NUM_CH | Request-enable bitmap |
| start_pulse | output | NUM_CH | One-cycle start request per channel |
| cfg_clk_gate | output | 1 | Clock gating enable |
| cfg_rr_group | output | 1 | Round-robin group arbitration |
| cfg_rr_chan | output | 1 | Round-robin channel arbitration |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach are collisions: a set strobe landing on the same edge as a clear of the same bit, and a fresh fault landing on the same edge as the release of the frozen status. The stimulus reaches both by raising the strobe and starting the register write before the same clock edge, then reading the word back once the edge has passed. A second fault is also raised while the status is still held, to show that the pending-error bit changes while the status word does not.

// File: rtl/dma_creg_pkg.sv
package dma_creg_pkg;

   // word offsets (byte addresses)
   localparam logic [7:0] OFS_CFG      = 8'h00;
   localparam logic [7:0] OFS_ESTAT    = 8'h04;
   localparam logic [7:0] OFS_REQEN_HI = 8'h08;
   localparam logic [7:0] OFS_REQEN_LO = 8'h0C;
   localparam logic [7:0] OFS_EIEN_HI  = 8'h10;
   localparam logic [7:0] OFS_EIEN_LO  = 8'h14;
   localparam logic [7:0] OFS_CMD_A    = 8'h18;
   localparam logic [7:0] OFS_CMD_B    = 8'h1C;
   localparam logic [7:0] OFS_PEND_HI  = 8'h20;
   localparam logic [7:0] OFS_PEND_LO  = 8'h24;
   localparam logic [7:0] OFS_FAULT_HI = 8'h28;
   localparam logic [7:0] OFS_FAULT_LO = 8'h2C;

   // command slots, index = 4*word + lane; slot 7 is reserved
   typedef enum logic [2:0] {
      CMD_SET_REQEN = 3'd0,
      CMD_CLR_REQEN = 3'd1,
      CMD_SET_EIEN  = 3'd2,
      CMD_CLR_EIEN  = 3'd3,
      CMD_CLR_PEND  = 3'd4,
      CMD_CLR_FAULT = 3'd5,
      CMD_START     = 3'd6
   } cmd_e;
   localparam int unsigned NUM_CMD = 7;

   // configuration word bit positions
   localparam int unsigned CFG_CLKG_BIT = 31;
   localparam int unsigned CFG_RRG_BIT  = 3;
   localparam int unsigned CFG_RRC_BIT  = 2;

   // error status layout
   localparam int unsigned NUM_FLAGS    = 10;
   localparam int unsigned CHAN_W       = 6;
   localparam int unsigned ES_VALID_BIT = 31;
   localparam int unsigned ES_CHAN_LSB  = 8;
   localparam int unsigned ES_GPRI_BIT  = 15;
   localparam int unsigned ES_CPRI_BIT  = 14;

   localparam int unsigned MAX_CH = 64;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/dma_creg_cmd_decode.sv
module dma_creg_cmd_decode
   import dma_creg_pkg::*;
#(
   parameter int unsigned NUM_CH = 64
)(
   input  logic                            wr,
   input  logic                            sel_a,
   input  logic                            sel_b,
   input  logic [3:0]                      be,
   input  logic [31:0]                     wdata,
   output logic [NUM_CMD-1:0][NUM_CH-1:0]  cmd_hot
);

   always_comb begin
      cmd_hot = '0;
      for (int k = 0; k < 4; k++) begin
         int slot;
         slot = (sel_b ? 4 : 0) + k;
         if (wr && (sel_a || sel_b) && be[k] && slot < int'(NUM_CMD)) begin
            for (int ch = 0; ch < int'(NUM_CH); ch++) begin
               if (wdata[8*k +: 8] == 8'(ch))
                  cmd_hot[slot][ch] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dma_creg_bitmap.sv
module dma_creg_bitmap
   import dma_creg_pkg::*;
#(
   parameter int unsigned NUM_CH       = 64,
   parameter bit          CLEAR_ON_ONE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic [NUM_CH-1:0] clr_vec,
   output logic [NUM_CH-1:0] map
);

   localparam int unsigned PAD_W = 2 * 32;

   logic [PAD_W-1:0]  mask_pad;
   logic [PAD_W-1:0]  data_pad;
   logic [NUM_CH-1:0] wmask;
   logic [NUM_CH-1:0] wdat;
   logic [NUM_CH-1:0] map_nx;

   always_comb begin
      mask_pad = {(wr_hi ? lane_mask(be) : 32'h0), (wr_lo ? lane_mask(be) : 32'h0)};
      data_pad = {wdata, wdata};
      wmask    = mask_pad[NUM_CH-1:0];
      wdat     = data_pad[NUM_CH-1:0];
   end

   generate
      if (CLEAR_ON_ONE) begin : g_w1c
         always_comb map_nx = (map & ~(clr_vec | (wmask & wdat))) | set_vec;
      end else begin : g_rw
         always_comb map_nx = (((map & ~wmask) | (wdat & wmask)) & ~clr_vec) | set_vec;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) map <= '0;
      else        map <= map_nx;
   end

endmodule

// File: rtl/dma_creg_errstat.sv
module dma_creg_errstat
   import dma_creg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 err_evt,
   input  logic [CHAN_W-1:0]    err_chan,
   input  logic [NUM_FLAGS-1:0] err_flags,
   input  logic                 release_req,
   output logic [31:0]          status
);

   logic                 held;
   logic [CHAN_W-1:0]    held_chan;
   logic [NUM_FLAGS-1:0] held_flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held       <= 1'b0;
         held_chan  <= '0;
         held_flags <= '0;
      end else if (err_evt && (!held || release_req)) begin
         held       <= 1'b1;
         held_chan  <= err_chan;
         held_flags <= err_flags;
      end else if (release_req) begin
         held       <= 1'b0;
         held_chan  <= '0;
         held_flags <= '0;
      end
   end

   always_comb begin
      status                                  = '0;
      status[ES_VALID_BIT]                    = held;
      status[ES_CHAN_LSB +: CHAN_W]           = held_chan;
      status[ES_GPRI_BIT]                     = held_flags[9];
      status[ES_CPRI_BIT]                     = held_flags[8];
      status[7:0]                             = held_flags[7:0];
   end

endmodule

// File: rtl/dma_creg.sv
module dma_creg
   import dma_creg_pkg::*;
#(
   parameter int unsigned NUM_CH = 64,
   parameter int unsigned ADDR_W = 8
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [3:0]           bus_be,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_CH-1:0]    done_evt,
   input  logic                 err_evt,
   input  logic [5:0]           err_chan,
   input  logic [9:0]           err_flags,
   output logic [NUM_CH-1:0]    req_enable,
   output logic [NUM_CH-1:0]    start_pulse,
   output logic                 cfg_clk_gate,
   output logic                 cfg_rr_group,
   output logic                 cfg_rr_chan,
   output logic                 irq
);

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
         $error("dma_creg: NUM_CH must lie in 1..64");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("dma_creg: ADDR_W must be at least 6");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_CFG      = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_ESTAT    = ADDR_W'(OFS_ESTAT);
   localparam logic [ADDR_W-1:0] A_REQEN_HI = ADDR_W'(OFS_REQEN_HI);
   localparam logic [ADDR_W-1:0] A_REQEN_LO = ADDR_W'(OFS_REQEN_LO);
   localparam logic [ADDR_W-1:0] A_EIEN_HI  = ADDR_W'(OFS_EIEN_HI);
   localparam logic [ADDR_W-1:0] A_EIEN_LO  = ADDR_W'(OFS_EIEN_LO);
   localparam logic [ADDR_W-1:0] A_CMD_A    = ADDR_W'(OFS_CMD_A);
   localparam logic [ADDR_W-1:0] A_CMD_B    = ADDR_W'(OFS_CMD_B);
   localparam logic [ADDR_W-1:0] A_PEND_HI  = ADDR_W'(OFS_PEND_HI);
   localparam logic [ADDR_W-1:0] A_PEND_LO  = ADDR_W'(OFS_PEND_LO);
   localparam logic [ADDR_W-1:0] A_FAULT_HI = ADDR_W'(OFS_FAULT_HI);
   localparam logic [ADDR_W-1:0] A_FAULT_LO = ADDR_W'(OFS_FAULT_LO);
   localparam logic [31:0] CFG_MASK = (32'h1 << CFG_CLKG_BIT) |
                                      (32'h1 << CFG_RRG_BIT)  |
                                      (32'h1 << CFG_RRC_BIT);

   logic [NUM_CMD-1:0][NUM_CH-1:0] cmd_hot;
   logic [NUM_CH-1:0]              eien_map;
   logic [NUM_CH-1:0]              int_map;
   logic [NUM_CH-1:0]              err_map;
   logic [NUM_CH-1:0]              err_set;
   logic [31:0]                    cfg_q;
   logic [31:0]                    err_status;
   logic                           estat_release;

   // command byte slots
   dma_creg_cmd_decode #(.NUM_CH(NUM_CH)) i_cmd (
      .wr      (bus_wr),
      .sel_a   (bus_addr == A_CMD_A),
      .sel_b   (bus_addr == A_CMD_B),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .cmd_hot (cmd_hot)
   );

   // error strobe to one-hot channel
   always_comb begin
      err_set = '0;
      for (int ch = 0; ch < int'(NUM_CH); ch++)
         if (err_evt && err_chan == 6'(ch)) err_set[ch] = 1'b1;
   end

   dma_creg_bitmap #(.NUM_CH(NUM_CH), .CLEAR_ON_ONE(1'b0)) i_reqen (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (bus_wr && bus_addr == A_REQEN_HI),
      .wr_lo   (bus_wr && bus_addr == A_REQEN_LO),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .set_vec (cmd_hot[CMD_SET_REQEN]),
      .clr_vec (cmd_hot[CMD_CLR_REQEN]),
      .map     (req_enable)
   );

   dma_creg_bitmap #(.NUM_CH(NUM_CH), .CLEAR_ON_ONE(1'b0)) i_eien (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (bus_wr && bus_addr == A_EIEN_HI),
      .wr_lo   (bus_wr && bus_addr == A_EIEN_LO),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .set_vec (cmd_hot[CMD_SET_EIEN]),
      .clr_vec (cmd_hot[CMD_CLR_EIEN]),
      .map     (eien_map)
   );

   dma_creg_bitmap #(.NUM_CH(NUM_CH), .CLEAR_ON_ONE(1'b1)) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (bus_wr && bus_addr == A_PEND_HI),
      .wr_lo   (bus_wr && bus_addr == A_PEND_LO),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .set_vec (done_evt),
      .clr_vec (cmd_hot[CMD_CLR_PEND]),
      .map     (int_map)
   );

   dma_creg_bitmap #(.NUM_CH(NUM_CH), .CLEAR_ON_ONE(1'b1)) i_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (bus_wr && bus_addr == A_FAULT_HI),
      .wr_lo   (bus_wr && bus_addr == A_FAULT_LO),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .set_vec (err_set),
      .clr_vec (cmd_hot[CMD_CLR_FAULT]),
      .map     (err_map)
   );

   assign estat_release = bus_wr && bus_addr == A_ESTAT && bus_be[3] && bus_wdata[ES_VALID_BIT];

   dma_creg_errstat i_estat (
      .clk         (clk),
      .rst_n       (rst_n),
      .err_evt     (err_evt),
      .err_chan    (err_chan),
      .err_flags   (err_flags),
      .release_req (estat_release),
      .status      (err_status)
   );

   // configuration word and start pulses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         start_pulse <= '0;
      end else begin
         if (bus_wr && bus_addr == A_CFG)
            cfg_q <= (cfg_q & ~(lane_mask(bus_be) & CFG_MASK)) |
                     (bus_wdata & lane_mask(bus_be) & CFG_MASK);
         start_pulse <= cmd_hot[CMD_START];
      end
   end

   assign cfg_clk_gate = cfg_q[CFG_CLKG_BIT];
   assign cfg_rr_group = cfg_q[CFG_RRG_BIT];
   assign cfg_rr_chan  = cfg_q[CFG_RRC_BIT];

   assign irq = (|int_map) | (|(err_map & eien_map));

   // read mux over zero-padded bitmaps
   logic [63:0] reqen_p, eien_p, int_p, err_p;
   always_comb begin
      reqen_p = 64'(req_enable);
      eien_p  = 64'(eien_map);
      int_p   = 64'(int_map);
      err_p   = 64'(err_map);
      unique case (bus_addr)
         A_CFG:      bus_rdata = cfg_q;
         A_ESTAT:    bus_rdata = err_status;
         A_REQEN_HI: bus_rdata = reqen_p[63:32];
         A_REQEN_LO: bus_rdata = reqen_p[31:0];
         A_EIEN_HI:  bus_rdata = eien_p[63:32];
         A_EIEN_LO:  bus_rdata = eien_p[31:0];
         A_PEND_HI:  bus_rdata = int_p[63:32];
         A_PEND_LO:  bus_rdata = int_p[31:0];
         A_FAULT_HI: bus_rdata = err_p[63:32];
         A_FAULT_LO: bus_rdata = err_p[31:0];
         default:    bus_rdata = 32'h0;
      endcase
   end

endmodule

// File: rtl/dma_creg_chk.sv
module dma_creg_chk #(
   parameter int unsigned NUM_CH = 64,
   parameter int unsigned ADDR_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [31:0]       bus_wdata,
   input logic [NUM_CH-1:0] done_evt,
   input logic              err_evt,
   input logic [NUM_CH-1:0] start_pulse,
   input logic [NUM_CH-1:0] int_map,
   input logic [31:0]       err_status
);

   logic rel_wr;
   assign rel_wr = bus_wr && bus_addr == ADDR_W'(8'h04) && bus_be[3] && bus_wdata[31];

   // R5: at most one channel started per cycle
   a_r5_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_pulse));

   // R5: a start pulse follows a bus write
   a_r5_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse != '0) |-> $past(bus_wr));

   // R6 / R8: a completion strobe always leaves its bit set
   a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt != '0) |=> ((int_map & $past(done_evt)) == $past(done_evt)));

   // R10: held status does not move without a release
   a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      (err_status[31] && !rel_wr) |=> (err_status == $past(err_status)));

   // R9: first fault sets valid
   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_status[31] && err_evt) |=> err_status[31]);

   // R11: release without a new fault empties the status
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      (err_status[31] && rel_wr && !err_evt) |=> !err_status[31]);

endmodule

bind dma_creg dma_creg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_be      (bus_be),
   .bus_wdata   (bus_wdata),
   .done_evt    (done_evt),
   .err_evt     (err_evt),
   .start_pulse (start_pulse),
   .int_map     (int_map),
   .err_status  (err_status)
);

// File: tb/test_dma_creg.sv
module test_dma_creg;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 64;

   typedef struct packed {
      logic [7:0]  addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t [0:7] VECS = '{
      '{8'h00, 4'hF, 32'hFFFF_FFFF, 8'h00, 32'h8000_000C},  // R2
      '{8'h08, 4'h3, 32'h1234_5678, 8'h08, 32'h0000_5678},  // R3 byte lanes
      '{8'h0C, 4'hF, 32'hA5A5_A5A5, 8'h0C, 32'hA5A5_A5A5},  // R3
      '{8'h10, 4'hF, 32'hFFFF_0000, 8'h10, 32'hFFFF_0000},  // R3
      '{8'h14, 4'hF, 32'h0000_000F, 8'h14, 32'h0000_000F},  // R3
      '{8'h30, 4'hF, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000},  // R13
      '{8'h00, 4'hF, 32'h0000_0004, 8'h00, 32'h0000_0004},  // R2
      '{8'h04, 4'hF, 32'hFFFF_FF00, 8'h04, 32'h0000_0000}   // R11 no fault held
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic [3:0]      bus_be = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCH-1:0]  done_evt = '0;
   logic            err_evt = 1'b0;
   logic [5:0]      err_chan = '0;
   logic [9:0]      err_flags = '0;
   logic [NCH-1:0]  req_enable;
   logic [NCH-1:0]  start_pulse;
   logic            cfg_clk_gate, cfg_rr_group, cfg_rr_chan, irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_creg #(.NUM_CH(NCH), .ADDR_W(8)) i_dma_creg (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .done_evt(done_evt), .err_evt(err_evt), .err_chan(err_chan),
      .err_flags(err_flags), .req_enable(req_enable), .start_pulse(start_pulse),
      .cfg_clk_gate(cfg_clk_gate), .cfg_rr_group(cfg_rr_group),
      .cfg_rr_chan(cfg_rr_chan), .irq(irq)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, {32'h0, bus_rdata}, {32'h0, exp});
   endtask

   task automatic fault(input logic [5:0] ch, input logic [9:0] fl);
      err_evt = 1'b1; err_chan = ch; err_flags = fl;
      @(negedge clk);
      err_evt = 1'b0; err_chan = '0; err_flags = '0;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic check_reset_state;
      rd("R1 cfg", 8'h00, 32'h0);
      rd("R1 estat", 8'h04, 32'h0);
      rd("R1 reqen hi", 8'h08, 32'h0);
      rd("R1 reqen lo", 8'h0C, 32'h0);
      rd("R1 eien hi", 8'h10, 32'h0);
      rd("R1 eien lo", 8'h14, 32'h0);
      rd("R1 pend hi", 8'h20, 32'h0);
      rd("R1 pend lo", 8'h24, 32'h0);
      rd("R1 fault hi", 8'h28, 32'h0);
      rd("R1 fault lo", 8'h2C, 32'h0);
      check("R1 irq", 64'(irq), 64'h0);
      check("R1 req_enable", req_enable, 64'h0);
      check("R1 start_pulse", start_pulse, 64'h0);
      check("R1 cfg outs", 64'({cfg_clk_gate, cfg_rr_group, cfg_rr_chan}), 64'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      check_reset_state();

      // table of register read/write vectors
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         wr(VECS[i].addr, VECS[i].be, VECS[i].wdata);
         rd($sformatf("R2/R3/R13 vector %0d", i), VECS[i].raddr, VECS[i].exp);
      end
      check("R2 cfg outs", 64'({cfg_clk_gate, cfg_rr_group, cfg_rr_chan}), 64'b001);
      check("R3 req_enable port", req_enable, 64'h0000_5678_A5A5_A5A5);

      @(negedge clk);
      do_reset();
      check_reset_state();

      // R4 command slots
      wr(8'h18, 4'b0001, 32'd5);
      rd("R4 set reqen ch5", 8'h0C, 32'h20);
      check("R4 req_enable ch5", req_enable, 64'h20);
      wr(8'h18, 4'b0001, 32'd40);
      rd("R4 set reqen ch40", 8'h08, 32'h100);
      wr(8'h18, 4'b0010, 32'd5 << 8);
      rd("R4 clr reqen ch5", 8'h0C, 32'h0);
      wr(8'h18, 4'b0001, 32'd70);
      rd("R4 out of range hi", 8'h08, 32'h100);
      rd("R4 out of range lo", 8'h0C, 32'h0);
      wr(8'h18, 4'b0100, 32'd3 << 16);
      rd("R4 set eien ch3", 8'h14, 32'h8);
      wr(8'h18, 4'b1000, 32'd3 << 24);
      rd("R4 clr eien ch3", 8'h14, 32'h0);
      wr(8'h1C, 4'b1000, 32'd9 << 24);
      check("R4 reserved slot no start", start_pulse, 64'h0);
      rd("R4 reserved slot reqen", 8'h0C, 32'h0);

      // R5 start pulse
      wr(8'h1C, 4'b0100, 32'd7 << 16);
      check("R5 start pulse ch7", start_pulse, 64'h80);
      @(negedge clk);
      check("R5 start pulse gone", start_pulse, 64'h0);
      wr(8'h1C, 4'b0100, 32'd63 << 16);
      check("R5 start pulse ch63", start_pulse, 64'h8000_0000_0000_0000);
      @(negedge clk);

      // R6 / R7 / R12 pending interrupts
      done_evt = (64'h1 << 33) | 64'h2;
      @(negedge clk);
      done_evt = '0;
      rd("R6 pend hi", 8'h20, 32'h2);
      rd("R6 pend lo", 8'h24, 32'h2);
      check("R12 irq from pend", 64'(irq), 64'h1);
      wr(8'h20, 4'hF, 32'h0);
      rd("R7 zero write keeps", 8'h20, 32'h2);
      wr(8'h20, 4'hF, 32'h2);
      rd("R7 w1c hi", 8'h20, 32'h0);
      wr(8'h24, 4'b0001, 32'h2);
      rd("R7 w1c lo", 8'h24, 32'h0);
      check("R12 irq low", 64'(irq), 64'h0);
      done_evt = 64'h10;
      @(negedge clk);
      done_evt = '0;
      wr(8'h1C, 4'b0001, 32'd4);
      rd("R4 clr pend ch4", 8'h24, 32'h0);

      // R8 event wins over clear
      done_evt = 64'h4;
      wr(8'h24, 4'hF, 32'hFFFF_FFFF);
      done_evt = '0;
      rd("R8 set beats w1c", 8'h24, 32'h4);
      wr(8'h24, 4'hF, 32'h4);
      rd("R8 cleared after", 8'h24, 32'h0);

      // R9 / R10 / R11 / R12 error status
      fault(6'd37, 10'b10_0000_0001);
      rd("R9 status capture", 8'h04, 32'h8000_A501);
      rd("R6 fault hi", 8'h28, 32'h20);
      check("R12 masked fault no irq", 64'(irq), 64'h0);
      wr(8'h18, 4'b0100, 32'd37 << 16);
      check("R12 enabled fault irq", 64'(irq), 64'h1);
      fault(6'd2, 10'b00_0000_0100);
      rd("R10 status held", 8'h04, 32'h8000_A501);
      rd("R10 second fault bit", 8'h2C, 32'h4);
      wr(8'h1C, 4'b0010, 32'd37 << 8);
      rd("R4 clr fault ch37", 8'h28, 32'h0);
      check("R12 irq after clear", 64'(irq), 64'h0);
      wr(8'h04, 4'b1000, 32'h8000_0000);
      rd("R11 release", 8'h04, 32'h0);
      err_evt = 1'b1; err_chan = 6'd1; err_flags = 10'b01_0000_0000;
      wr(8'h04, 4'hF, 32'hFFFF_FFFF);
      err_evt = 1'b0; err_chan = '0; err_flags = '0;
      rd("R11 capture on release", 8'h04, 32'h8000_4100);
      wr(8'h04, 4'hF, 32'h7FFF_FFFF);
      rd("R11 no release without bit31", 8'h04, 32'h8000_4100);
      wr(8'h04, 4'b0111, 32'hFFFF_FFFF);
      rd("R11 no release without lane3", 8'h04, 32'h8000_4100);

      // R13 misaligned access
      wr(8'h0D, 4'hF, 32'hFFFF_FFFF);
      rd("R13 misaligned read", 8'h0D, 32'h0);
      rd("R13 misaligned write ignored", 8'h0C, 32'h0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule